// File: doc/BRIEF.md
# Pre/Post-Trigger Circular Capture Buffer

This block sits behind an ADC sample stream and keeps a rolling history of the stream in a circular RAM. While it is armed, every sample strobe writes one sample and advances the write pointer, wrapping at the end of the RAM. This way the most recent samples are always on hand. When a trigger is accepted, the block takes a programmed number of further samples and then stops writing. The finished record is the N samples before the trigger followed by the M samples after it. The block streams that record out oldest first on a valid/ready interface, raises a one-cycle completion pulse, and re-arms by itself.

The pre-trigger length N and post-trigger length M are configuration inputs. They are evaluated while the block waits for a trigger and must be held steady through a capture. A trigger that comes too early (before N samples have been written since arming) or while the configuration is invalid is held pending, not lost. A trigger that comes while a capture is being completed or read out is dropped and counted.

Top module: `capture_buffer`

## Requirements
- R1: After reset, outValid, outLast and captureDone are 0 and overrunCnt is 0.
- R2: The first N beats of a record are the N most recent samples written up to and including the sample strobed in the cycle the trigger is accepted, delivered oldest first.
- R3: A trigger is accepted only once at least N samples have been written since the block was last armed. An earlier trigger pulse is remembered and accepted in the first cycle in which the count reaches N.
- R4: After the pre-trigger samples, the record carries exactly the next M strobed samples in arrival order, for N+M beats in total. outLast is 1 on the final beat only.
- R5: After the edge that stores the M-th post-trigger sample there is one cycle with outValid low, and then outValid goes high. Samples strobed from that point until the record has been fully read are not stored.
- R6: While outValid is 1 and outReady is 0, outValid stays 1 and outData and outLast hold their values at the next edge.
- R7: captureDone is a one-cycle pulse in the cycle after the final beat is accepted. The block is then armed again with its since-arm sample count back at zero.
- R8: Each cycle in which trigIn is 1 while the block is collecting post-trigger samples, waiting to read out or reading out adds one to overrunCnt, which saturates at its all-ones value. Such pulses never start a new record.
- R9: A configuration with M equal to 0, or with N+M greater than the RAM depth, is invalid. While it is present, a trigger stays pending and no record starts. Once the configuration becomes valid, the pending trigger is accepted.
- R10: With N equal to 0, the record is exactly the M samples strobed after the accepting cycle. Records whose window runs past the last RAM address read out in the same order as records that do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | One-cycle strobe per ADC sample |
| sampleData | input | DATA_W | ADC sample value |
| trigIn | input | 1 | Trigger request, one event per high cycle |
| preLen | input | CW | Pre-trigger sample count N |
| postLen | input | CW | Post-trigger sample count M |
| outValid | output | 1 | Readout beat valid |
| outReady | input | 1 | Downstream accepts the beat |
| outData | output | DATA_W | Readout sample |
| outLast | output | 1 | Final beat of the record |
| captureDone | output | 1 | Completion pulse, block re-armed |
| overrunCnt | output | OVW | Saturating count of ignored triggers |

## Verification
The capture path is run with steady strobes and with sparse random strobes. This separates a pointer that advances every cycle from one that advances only on samples. Triggers are placed early (pending), late (immediate), during post-capture and readout (ignored), and under an invalid length pair. This tells the pending, accepting and counting paths apart. Readout is run with outReady held high, with it toggled at random, and with it held low for long stretches. This exercises the prefetch address path under stall. A long pre-window and an N of zero probe the start-address subtraction at both ends and across the RAM wrap.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,
    ST_POST  = 2'd1,
    ST_PRIME = 2'd2,
    ST_READ  = 2'd3
  } capState_t;

  typedef struct packed {
    logic wrEn;
    logic loadRd;
    logic advRd;
  } capStrobe_t;

endpackage

// File: rtl/cap_datapath.sv
module cap_datapath
  import cap_pkg::*;
#(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned AW     = $clog2(DEPTH),
  parameter int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        strobe,
  input  logic [DATA_W-1:0] sampleData,
  input  logic [CW-1:0]     preLen,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [CW:0]   DEPTH_X   = (CW + 1)'(DEPTH);

  function automatic logic [AW-1:0] incPtr(input logic [AW-1:0] p);
    return (p == LAST_ADDR) ? '0 : p + 1'b1;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, wrPtrNext, rdPtr, rdAddr, startPtr;
  logic [CW:0]       wpWide, preWide, startWide;

  assign wrPtrNext = strobe.wrEn ? incPtr(wrPtr) : wrPtr;
  assign wpWide    = (CW + 1)'(wrPtrNext);
  assign preWide   = (CW + 1)'(preLen);

  // Oldest pre-trigger sample sits N entries behind the next write slot.
  always_comb begin
    if (wpWide >= preWide) startWide = wpWide - preWide;
    else                   startWide = wpWide + DEPTH_X - preWide;
  end
  assign startPtr = AW'(startWide);

  // Look-ahead address keeps the registered read output on the current beat.
  assign rdAddr = strobe.advRd ? incPtr(rdPtr) : rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      wrPtr <= wrPtrNext;
      if (strobe.loadRd)     rdPtr <= startPtr;
      else if (strobe.advRd) rdPtr <= incPtr(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[wrPtr] <= sampleData;
    rdData <= mem[rdAddr];
  end

  // R5: the read pointer is never moved by a beat while samples are being stored
  a_r5_no_read_while_write: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> !strobe.advRd);

endmodule

// File: rtl/cap_control.sv
module cap_control
  import cap_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned CW    = $clog2(DEPTH + 1),
  parameter int unsigned OVW   = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           sampleValid,
  input  logic           trigIn,
  input  logic           outReady,
  input  logic [CW-1:0]  preLen,
  input  logic [CW-1:0]  postLen,
  output capStrobe_t     strobe,
  output logic           outValid,
  output logic           outLast,
  output logic           captureDone,
  output logic [OVW-1:0] overrunCnt
);

  localparam logic [CW-1:0]  DEPTH_C = CW'(DEPTH);
  localparam logic [CW:0]    DEPTH_X = (CW + 1)'(DEPTH);
  localparam logic [OVW-1:0] OV_MAX  = '1;

  capState_t     state;
  logic [CW-1:0] armCnt, armNext, postLeft, readLeft, nLat;
  logic [CW:0]   sumLen;
  logic          pending, cfgOk, accept, fire, armed;

  assign armed   = (state == ST_FILL);
  assign sumLen  = {1'b0, preLen} + {1'b0, postLen};
  assign cfgOk   = (postLen != '0) && (sumLen <= DEPTH_X);
  assign armNext = (armCnt == DEPTH_C) ? armCnt : armCnt + CW'(sampleValid);
  assign accept  = armed && (trigIn || pending) && (armNext >= preLen) && cfgOk;

  assign outValid = (state == ST_READ);
  assign outLast  = outValid && (readLeft == CW'(1));
  assign fire     = outValid && outReady;

  always_comb begin
    strobe        = '0;
    strobe.wrEn   = sampleValid && (armed || state == ST_POST);
    strobe.loadRd = accept;
    strobe.advRd  = fire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_FILL;
      armCnt      <= '0;
      pending     <= 1'b0;
      postLeft    <= '0;
      readLeft    <= '0;
      nLat        <= '0;
      captureDone <= 1'b0;
    end else begin
      captureDone <= 1'b0;
      unique case (state)
        ST_FILL: begin
          armCnt <= armNext;
          if (accept) begin
            pending  <= 1'b0;
            postLeft <= postLen;
            readLeft <= CW'(sumLen);
            nLat     <= preLen;
            state    <= ST_POST;
          end else if (trigIn) begin
            pending <= 1'b1;
          end
        end
        ST_POST: begin
          if (sampleValid) begin
            postLeft <= postLeft - 1'b1;
            if (postLeft == CW'(1)) state <= ST_PRIME;
          end
        end
        ST_PRIME: state <= ST_READ;
        ST_READ: begin
          if (fire) begin
            readLeft <= readLeft - 1'b1;
            if (readLeft == CW'(1)) begin
              state       <= ST_FILL;
              armCnt      <= '0;
              captureDone <= 1'b1;
            end
          end
        end
        default: state <= ST_FILL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                        overrunCnt <= '0;
    else if (trigIn && !armed && overrunCnt != OV_MAX) overrunCnt <= overrunCnt + 1'b1;
  end

  // R3: post-trigger collection only begins once the pre-window is filled
  a_r3_prewindow_filled: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_POST) |-> (armCnt >= nLat));

  // R8: the ignored-trigger count never moves backwards
  a_r8_overrun_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    overrunCnt >= $past(overrunCnt));

  // R7: completion is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    captureDone |=> !captureDone);

  // R9: a record never holds more entries than the RAM
  a_r9_record_fits: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (readLeft != '0) && (readLeft <= DEPTH_C));

endmodule

// File: rtl/capture_buffer.sv
module capture_buffer
  import cap_pkg::*;
#(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned OVW    = 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              trigIn,
  input  logic [CW-1:0]     preLen,
  input  logic [CW-1:0]     postLen,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              outLast,
  output logic              captureDone,
  output logic [OVW-1:0]    overrunCnt
);

  capStrobe_t strobe;

  cap_control #(
    .DEPTH (DEPTH),
    .CW    (CW),
    .OVW   (OVW)
  ) u_control (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .trigIn      (trigIn),
    .outReady    (outReady),
    .preLen      (preLen),
    .postLen     (postLen),
    .strobe      (strobe),
    .outValid    (outValid),
    .outLast     (outLast),
    .captureDone (captureDone),
    .overrunCnt  (overrunCnt)
  );

  cap_datapath #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .AW     (AW),
    .CW     (CW)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .sampleData (sampleData),
    .preLen     (preLen),
    .rdData     (outData)
  );

  // R6: a stalled beat keeps its payload
  a_r6_hold_beat: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  // R4: the final-beat marker only accompanies a valid beat
  a_r4_last_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

endmodule

// File: tb/capture_buffer_bench.sv
module capture_buffer_bench;

  localparam int DATA_W = 14;
  localparam int DEPTH  = 512;
  localparam int OVW    = 8;
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int OV_MAX = (1 << OVW) - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sampleValid = 1'b0;
  logic [DATA_W-1:0] sampleData = '0;
  logic              trigIn = 1'b0;
  logic [CW-1:0]     preLen = '0;
  logic [CW-1:0]     postLen = CW'(1);
  logic              outValid, outLast, captureDone;
  logic              outReady = 1'b0;
  logic [DATA_W-1:0] outData;
  logic [OVW-1:0]    overrunCnt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  capture_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH), .OVW(OVW)) u_capture_buffer (
    .clk, .rstN, .sampleValid, .sampleData, .trigIn, .preLen, .postLen,
    .outValid, .outReady, .outData, .outLast, .captureDone, .overrunCnt
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 armed, 1 post, 2 gap, 3 readout
  logic [DATA_W-1:0] hist[$];
  logic [DATA_W-1:0] expQ[$];
  int mPhase = 0, mArm = 0, mNeed = 0, mOvr = 0;
  bit mPend = 0, mDone = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mArm = 0; mNeed = 0; mOvr = 0; mPend = 0; mDone = 0;
      hist.delete(); expQ.delete();
    end else begin
      int n, m;
      n = int'(preLen);
      m = int'(postLen);
      mDone = 0;
      if (trigIn && mPhase != 0 && mOvr < OV_MAX) mOvr++;
      case (mPhase)
        0: begin
          if (sampleValid) begin
            hist.push_back(sampleData);
            if (hist.size() > DEPTH) void'(hist.pop_front());
            if (mArm < DEPTH) mArm++;
          end
          if ((trigIn || mPend) && mArm >= n && m >= 1 && n + m <= DEPTH) begin
            expQ.delete();
            for (int i = hist.size() - n; i < hist.size(); i++) expQ.push_back(hist[i]);
            mNeed = m; mPhase = 1; mPend = 0;
          end else if (trigIn) begin
            mPend = 1;
          end
        end
        1: if (sampleValid) begin
          expQ.push_back(sampleData);
          mNeed--;
          if (mNeed == 0) mPhase = 2;
        end
        2: mPhase = 3;
        default: if (outReady) begin
          void'(expQ.pop_front());
          if (expQ.size() == 0) begin
            mDone = 1; mPhase = 0; mArm = 0; hist.delete();
          end
        end
      endcase
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      bit expValid;
      expValid = (mPhase == 3);
      chk(outValid == expValid, "R5", "outValid", int'(outValid), int'(expValid));
      if (expValid && outValid) begin
        chk(outData == expQ[0], "R2/R4/R6/R10", "outData", int'(outData), int'(expQ[0]));
        chk(outLast == (expQ.size() == 1), "R4", "outLast", int'(outLast),
            int'(expQ.size() == 1));
      end
      chk(captureDone == mDone, "R7", "captureDone", int'(captureDone), int'(mDone));
      chk(int'(overrunCnt) == mOvr, "R8", "overrunCnt", int'(overrunCnt), mOvr);
    end
  end

  task automatic cyc(input bit v, input bit t, input bit r);
    sampleValid = v;
    sampleData  = DATA_W'($urandom);
    trigIn      = t;
    outReady    = r;
    @(negedge clk);
  endtask

  task automatic runFill(input int n, input int pctValid);
    for (int i = 0; i < n; i++) cyc(($urandom % 100) < pctValid, 1'b0, 1'b1);
  endtask

  task automatic waitDone(input int pctReady, input int pctTrig);
    for (int i = 0; i < 6000; i++) begin
      cyc(1'b1, ($urandom % 100) < pctTrig, ($urandom % 100) < pctReady);
      if (captureDone) break;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(outValid == 1'b0, "R1", "outValid", int'(outValid), 0);
    chk(outLast == 1'b0, "R1", "outLast", int'(outLast), 0);
    chk(captureDone == 1'b0, "R1", "captureDone", int'(captureDone), 0);
    chk(overrunCnt == '0, "R1", "overrunCnt", int'(overrunCnt), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R4: basic record, steady strobes, full-speed readout
    preLen = CW'(8); postLen = CW'(8);
    runFill(20, 100);
    cyc(1'b1, 1'b1, 1'b1);
    waitDone(100, 0);

    // R3 R7: early trigger right after re-arm, sparse strobes
    preLen = CW'(20); postLen = CW'(6);
    cyc(1'b0, 1'b1, 1'b1);
    runFill(10, 50);
    chk(outValid == 1'b0, "R3", "outValid while pending", int'(outValid), 0);
    runFill(60, 60);
    waitDone(100, 0);

    // R6 R8: triggers during post-capture and readout, random backpressure
    preLen = CW'(16); postLen = CW'(10);
    runFill(30, 100);
    cyc(1'b1, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 1'b1);
    cyc(1'b0, 1'b1, 1'b1);
    waitDone(40, 20);

    // R9: invalid length pair keeps the trigger pending
    preLen = CW'(500); postLen = CW'(20);
    runFill(600, 100);
    cyc(1'b1, 1'b1, 1'b1);
    runFill(30, 100);
    chk(outValid == 1'b0, "R9", "outValid with oversize config", int'(outValid), 0);
    postLen = CW'(0); preLen = CW'(4);
    runFill(10, 100);
    chk(outValid == 1'b0, "R9", "outValid with zero post length", int'(outValid), 0);
    preLen = CW'(500); postLen = CW'(12);
    waitDone(70, 0);

    // R10: empty pre-window
    preLen = CW'(0); postLen = CW'(5);
    cyc(1'b1, 1'b1, 1'b1);
    waitDone(100, 0);

    // R10: long window that wraps the RAM
    preLen = CW'(300); postLen = CW'(200);
    runFill(700, 70);
    cyc(1'b1, 1'b1, 1'b1);
    waitDone(60, 5);

    // R8: overrun saturation under a long stall
    preLen = CW'(4); postLen = CW'(4);
    runFill(10, 100);
    cyc(1'b1, 1'b1, 1'b1);
    runFill(6, 100);
    for (int i = 0; i < 300; i++) cyc(1'b1, 1'b1, 1'b0);
    chk(int'(overrunCnt) == OV_MAX, "R8", "overrun saturation", int'(overrunCnt), OV_MAX);
    waitDone(100, 0);
    runFill(5, 100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule